// File: doc/BRIEF.md
# SIMD Multiply-Accumulate Slice

A pipelined arithmetic slice for filter, accumulator and wide datapath work. Each cycle an opcode chooses what the slice does with the operands presented on that cycle. Multiply operations take a 25-bit and an 18-bit two's-complement factor. A pre-adder can first add a second 25-bit operand to the wide factor, which suits symmetric filters. Accumulating forms add the product to the 48-bit result register.

With the multiplier bypassed, two 48-bit operands go straight to a segmented adder. That adder works as one 48-bit lane, two 24-bit lanes or four 12-bit lanes, with a carry flag for each lane. The same operands can instead go to a bitwise logic unit with ten functions. The adder can also accumulate one operand into the result register in every lane, so it serves as an up/down counter.

Two parameters switch the input register and the product register in or out. A synchronous clear travels down the pipeline together with the operation.

Top module: `simd_mac_slice`

## Requirements
- R1: While `rst` is high and after it falls, `p_out` and `carry_out` are zero, and each pipeline stage holds a no-operation until real operations arrive.
- R2: An operation on the inputs at one rising edge shows its result on `p_out`/`carry_out` after 1+IN_REG+MUL_REG rising edges (3 by default). Back-to-back accumulating operations each see the result of the one before.
- R3: Opcode 0 gives sign-extend(a*b). Opcode 1 gives sign-extend((a+d)*b), where the sum a+d wraps to 25 bits before the multiply. Both ignore `simd_mode`.
- R4: Opcode 2 gives P+a*b and opcode 3 gives P+(a+d)*b, modulo 2^48, where P is the current result register.
- R5: Opcode 4 gives x+y and opcode 5 gives x-y, computed lane by lane. The lane mode is `simd_mode` 0 for 1x48, 1 for 2x24, 2 for 4x12, and 3 acts as 1x48. No carry crosses a lane boundary.
- R6: Opcode 6 gives P+x and opcode 7 gives P-x, per lane, with the lane modes of R5.
- R7: For opcodes 4 to 7, `carry_out[i]` is the carry out of lane i, with lane 0 in the least significant bits. A subtraction is done as u+~v+1, so its carry is 1 when there is no borrow. Bits above the lane count are 0. For all other opcodes `carry_out` is 0.
- R8: Opcode 8 sets the result from `logic_sel`: 0 AND, 1 OR, 2 XOR, 3 XNOR, 4 NAND, 5 NOR, 6 x AND NOT y, 7 NOT x, 8 x OR NOT y, 9 x. Values 10 to 15 give zero.
- R9: When `clr_acc` is set with an operation, the result register becomes zero and `carry_out` becomes 0 when that operation reaches the output, whatever the opcode.
- R10: Opcodes 9 to 15 leave `p_out` unchanged and drive `carry_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_in | input | 4 | Operation code |
| logic_sel | input | 4 | Logic function select for opcode 8 |
| simd_mode | input | 2 | Lane split of the adder |
| clr_acc | input | 1 | Clear the result register with this operation |
| mul_a | input | A_W | Wide multiplier factor, first pre-adder input |
| mul_d | input | A_W | Second pre-adder input |
| mul_b | input | B_W | Narrow multiplier factor |
| opnd_x | input | P_W | First bypass/logic operand |
| opnd_y | input | P_W | Second bypass/logic operand |
| p_out | output | P_W | Registered result / accumulator |
| carry_out | output | 4 | Per-lane carry flags |

## Verification
The hardest case to reach from the ports is a carry sitting exactly on a lane boundary. For random operands this is rare, and it only shows up as a wrong answer when the mode isolates the lanes. Directed operands fill every lane with ones and add one, in each of the three lane modes, so the edge carries must stop at each boundary in one case and ripple through in another. Random steps then mix accumulate, clear, pre-add and reserved codes back to back so that feedback from the result register happens in every pipeline slot.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;

  localparam int NSEG = 4;

  localparam logic [3:0] OP_MUL    = 4'd0;
  localparam logic [3:0] OP_PMUL   = 4'd1;
  localparam logic [3:0] OP_MACC   = 4'd2;
  localparam logic [3:0] OP_PMACC  = 4'd3;
  localparam logic [3:0] OP_ADD    = 4'd4;
  localparam logic [3:0] OP_SUB    = 4'd5;
  localparam logic [3:0] OP_ACCADD = 4'd6;
  localparam logic [3:0] OP_ACCSUB = 4'd7;
  localparam logic [3:0] OP_LOGIC  = 4'd8;
  localparam logic [3:0] OP_NOP    = 4'd15;

  typedef enum logic [1:0] {
    SIMD_ONE48  = 2'd0,
    SIMD_TWO24  = 2'd1,
    SIMD_FOUR12 = 2'd2,
    SIMD_ALT48  = 2'd3
  } simd_e;

  typedef struct packed {
    logic [3:0] op;
    logic [3:0] lsel;
    simd_e      simd;
    logic       clr;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{op: OP_NOP, lsel: 4'd0, simd: SIMD_ONE48, clr: 1'b0};

endpackage

// File: rtl/smac_pipe_reg.sv
module smac_pipe_reg #(
  parameter int           W       = 8,
  parameter bit           EN      = 1'b1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (EN) begin : g_reg
      logic [W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst) r <= RST_VAL;
        else     r <= d;
      end
      assign q = r;
    end else begin : g_wire
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/smac_mult.sv
module smac_mult #(
  parameter int A_W = 25,
  parameter int B_W = 18,
  parameter int P_W = 48
) (
  input  logic [A_W-1:0] a,
  input  logic [A_W-1:0] d,
  input  logic [B_W-1:0] b,
  input  logic           pre_en,
  output logic [P_W-1:0] prod
);

  localparam int M_W = A_W + B_W;

  logic [A_W-1:0] pre;
  logic [M_W-1:0] pre_ext, b_ext, full;

  // pre-adder result wraps to the factor width
  assign pre     = pre_en ? (a + d) : a;
  assign pre_ext = {{B_W{pre[A_W-1]}}, pre};
  assign b_ext   = {{A_W{b[B_W-1]}}, b};
  assign full    = pre_ext * b_ext;
  assign prod    = {{(P_W-M_W){full[M_W-1]}}, full};

endmodule

// File: rtl/smac_simd_adder.sv
module smac_simd_adder
  import simd_mac_pkg::*;
#(
  parameter int P_W = 48
) (
  input  logic [P_W-1:0]  u,
  input  logic [P_W-1:0]  v,
  input  logic            sub,
  input  simd_e           mode,
  output logic [P_W-1:0]  sum,
  output logic [NSEG-1:0] cout
);

  localparam int SEG_W = P_W / NSEG;

  logic [NSEG-1:0] cseg;

  generate
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
      logic cin_s;
      if (s == 0) begin : g_first
        assign cin_s = sub;
      end else begin : g_rest
        logic seg_start;
        assign seg_start = (mode == SIMD_FOUR12) || ((mode == SIMD_TWO24) && ((s % 2) == 0));
        assign cin_s     = seg_start ? sub : cseg[s-1];
      end
      assign {cseg[s], sum[s*SEG_W +: SEG_W]} =
        {1'b0, u[s*SEG_W +: SEG_W]} + {1'b0, v[s*SEG_W +: SEG_W]} + {{SEG_W{1'b0}}, cin_s};
    end
  endgenerate

  always_comb begin
    cout = '0;
    case (mode)
      SIMD_FOUR12: cout = cseg;
      SIMD_TWO24: begin
        cout[0] = cseg[1];
        cout[1] = cseg[3];
      end
      default: cout[0] = cseg[NSEG-1];
    endcase
  end

endmodule

// File: rtl/smac_logic_unit.sv
module smac_logic_unit #(
  parameter int P_W = 48
) (
  input  logic [P_W-1:0] a,
  input  logic [P_W-1:0] b,
  input  logic [3:0]     sel,
  output logic [P_W-1:0] res
);

  always_comb begin
    case (sel)
      4'd0:    res = a & b;
      4'd1:    res = a | b;
      4'd2:    res = a ^ b;
      4'd3:    res = ~(a ^ b);
      4'd4:    res = ~(a & b);
      4'd5:    res = ~(a | b);
      4'd6:    res = a & ~b;
      4'd7:    res = ~a;
      4'd8:    res = a | ~b;
      4'd9:    res = a;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/simd_mac_slice.sv
module simd_mac_slice
  import simd_mac_pkg::*;
#(
  parameter int A_W     = 25,
  parameter int B_W     = 18,
  parameter int P_W     = 48,
  parameter bit IN_REG  = 1'b1,
  parameter bit MUL_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_in,
  input  logic [3:0]       logic_sel,
  input  logic [1:0]       simd_mode,
  input  logic             clr_acc,
  input  logic [A_W-1:0]   mul_a,
  input  logic [A_W-1:0]   mul_d,
  input  logic [B_W-1:0]   mul_b,
  input  logic [P_W-1:0]   opnd_x,
  input  logic [P_W-1:0]   opnd_y,
  output logic [P_W-1:0]   p_out,
  output logic [NSEG-1:0]  carry_out
);

  localparam int LAT   = 1 + int'(IN_REG) + int'(MUL_REG);
  localparam int CTL_W = $bits(ctl_t);

  localparam logic [1:0] K_HOLD  = 2'd0;
  localparam logic [1:0] K_MUL   = 2'd1;
  localparam logic [1:0] K_ADD   = 2'd2;
  localparam logic [1:0] K_LOGIC = 2'd3;

  // ---------------- stage 0: optional input register ----------------
  ctl_t           ctl_in, ctl1, ctl2;
  logic [A_W-1:0] a1, d1;
  logic [B_W-1:0] b1;
  logic [P_W-1:0] x1, y1, x2, y2, prod1, prod2;

  assign ctl_in = '{op: op_in, lsel: logic_sel, simd: simd_e'(simd_mode), clr: clr_acc};

  smac_pipe_reg #(.W(CTL_W), .EN(IN_REG), .RST_VAL(CTL_IDLE)) u_s0_ctl
    (.clk(clk), .rst(rst), .d(ctl_in), .q(ctl1));
  smac_pipe_reg #(.W(A_W), .EN(IN_REG)) u_s0_a (.clk(clk), .rst(rst), .d(mul_a),  .q(a1));
  smac_pipe_reg #(.W(A_W), .EN(IN_REG)) u_s0_d (.clk(clk), .rst(rst), .d(mul_d),  .q(d1));
  smac_pipe_reg #(.W(B_W), .EN(IN_REG)) u_s0_b (.clk(clk), .rst(rst), .d(mul_b),  .q(b1));
  smac_pipe_reg #(.W(P_W), .EN(IN_REG)) u_s0_x (.clk(clk), .rst(rst), .d(opnd_x), .q(x1));
  smac_pipe_reg #(.W(P_W), .EN(IN_REG)) u_s0_y (.clk(clk), .rst(rst), .d(opnd_y), .q(y1));

  // ---------------- stage 1: pre-adder and multiplier ----------------
  logic pre_en;
  assign pre_en = (ctl1.op == OP_PMUL) || (ctl1.op == OP_PMACC);

  smac_mult #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) u_mult
    (.a(a1), .d(d1), .b(b1), .pre_en(pre_en), .prod(prod1));

  smac_pipe_reg #(.W(CTL_W), .EN(MUL_REG), .RST_VAL(CTL_IDLE)) u_s1_ctl
    (.clk(clk), .rst(rst), .d(ctl1), .q(ctl2));
  smac_pipe_reg #(.W(P_W), .EN(MUL_REG)) u_s1_p (.clk(clk), .rst(rst), .d(prod1), .q(prod2));
  smac_pipe_reg #(.W(P_W), .EN(MUL_REG)) u_s1_x (.clk(clk), .rst(rst), .d(x1),    .q(x2));
  smac_pipe_reg #(.W(P_W), .EN(MUL_REG)) u_s1_y (.clk(clk), .rst(rst), .d(y1),    .q(y2));

  // ---------------- stage 2: adder / logic unit and result register ----------------
  logic [P_W-1:0]  p_q, alu_u, alu_v, alu_sum, lres;
  logic [NSEG-1:0] c_q, alu_cout;
  logic            alu_sub;
  simd_e           alu_mode;
  logic [1:0]      kind;

  always_comb begin
    alu_u    = '0;
    alu_v    = '0;
    alu_sub  = 1'b0;
    alu_mode = ctl2.simd;
    kind     = K_HOLD;
    case (ctl2.op)
      OP_MUL, OP_PMUL: begin
        alu_v    = prod2;
        alu_mode = SIMD_ONE48;
        kind     = K_MUL;
      end
      OP_MACC, OP_PMACC: begin
        alu_u    = p_q;
        alu_v    = prod2;
        alu_mode = SIMD_ONE48;
        kind     = K_MUL;
      end
      OP_ADD: begin
        alu_u = x2;
        alu_v = y2;
        kind  = K_ADD;
      end
      OP_SUB: begin
        alu_u   = x2;
        alu_v   = ~y2;
        alu_sub = 1'b1;
        kind    = K_ADD;
      end
      OP_ACCADD: begin
        alu_u = p_q;
        alu_v = x2;
        kind  = K_ADD;
      end
      OP_ACCSUB: begin
        alu_u   = p_q;
        alu_v   = ~x2;
        alu_sub = 1'b1;
        kind    = K_ADD;
      end
      OP_LOGIC: kind = K_LOGIC;
      default:  kind = K_HOLD;
    endcase
  end

  smac_simd_adder #(.P_W(P_W)) u_adder
    (.u(alu_u), .v(alu_v), .sub(alu_sub), .mode(alu_mode), .sum(alu_sum), .cout(alu_cout));

  smac_logic_unit #(.P_W(P_W)) u_logic
    (.a(x2), .b(y2), .sel(ctl2.lsel), .res(lres));

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q <= '0;
      c_q <= '0;
    end else if (ctl2.clr) begin
      p_q <= '0;
      c_q <= '0;
    end else begin
      case (kind)
        K_MUL: begin
          p_q <= alu_sum;
          c_q <= '0;
        end
        K_ADD: begin
          p_q <= alu_sum;
          c_q <= alu_cout;
        end
        K_LOGIC: begin
          p_q <= lres;
          c_q <= '0;
        end
        default: c_q <= '0;
      endcase
    end
  end

  assign p_out     = p_q;
  assign carry_out = c_q;

  // ---------------- assertions ----------------
  logic [1:0] fill_cnt;
  always_ff @(posedge clk) begin
    if (rst)                    fill_cnt <= '0;
    else if (fill_cnt != 2'(LAT)) fill_cnt <= fill_cnt + 2'd1;
  end

  AST_CLEAR_REACHES_OUT: assert property (@(posedge clk) disable iff (rst)
    (fill_cnt == 2'(LAT) && $past(clr_acc, LAT)) |-> (p_out == '0 && carry_out == '0)) // R9
    else $error("clear did not zero the result");

  AST_RSVD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (ctl2.op > OP_LOGIC && !ctl2.clr) |=> $stable(p_out)) // R10
    else $error("reserved opcode changed the result");

  AST_ONE_LANE_CARRY: assert property (@(posedge clk) disable iff (rst)
    (ctl2.simd inside {SIMD_ONE48, SIMD_ALT48}) |=> (carry_out[NSEG-1:1] == '0)) // R7
    else $error("carry above lane 0 in 1x48 mode");

  AST_TWO_LANE_CARRY: assert property (@(posedge clk) disable iff (rst)
    (ctl2.simd == SIMD_TWO24) |=> (carry_out[NSEG-1:2] == '0)) // R7
    else $error("carry above lane 1 in 2x24 mode");

  AST_NO_CARRY_NONADD: assert property (@(posedge clk) disable iff (rst)
    (ctl2.op <= OP_PMACC || ctl2.op >= OP_LOGIC) |=> (carry_out == '0)) // R7
    else $error("carry flag set by a non add/sub opcode");

endmodule

// File: tb/test_simd_mac_slice.sv
`timescale 1ns/1ps
module test_simd_mac_slice;

  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_in = 4'd15, logic_sel = '0;
  logic [1:0]  simd_mode = '0;
  logic        clr_acc = 1'b0;
  logic [24:0] mul_a = '0, mul_d = '0;
  logic [17:0] mul_b = '0;
  logic [47:0] opnd_x = '0, opnd_y = '0;
  logic [47:0] p_out;
  logic [3:0]  carry_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [47:0] model_acc = '0;
  logic [47:0] qp[$];
  logic [3:0]  qc[$];
  string       qt[$];

  always #2.5 clk = ~clk;

  simd_mac_slice #(.A_W(25), .B_W(18), .P_W(48), .IN_REG(1'b1), .MUL_REG(1'b1)) i_simd_mac_slice (
    .clk(clk), .rst(rst), .op_in(op_in), .logic_sel(logic_sel), .simd_mode(simd_mode),
    .clr_acc(clr_acc), .mul_a(mul_a), .mul_d(mul_d), .mul_b(mul_b),
    .opnd_x(opnd_x), .opnd_y(opnd_y), .p_out(p_out), .carry_out(carry_out));

  function automatic void lanes(input logic [47:0] u, input logic [47:0] v, input logic sub,
                                input logic [1:0] sm, output logic [47:0] s, output logic [3:0] c);
    int w;
    w = (sm == 2'd2) ? 12 : (sm == 2'd1) ? 24 : 48;
    s = '0;
    c = '0;
    for (int i = 0; i < 48 / w; i++) begin
      logic [63:0] m, uu, vv, r;
      m  = (64'd1 << w) - 64'd1;
      uu = (64'(u) >> (i * w)) & m;
      vv = (64'(v) >> (i * w)) & m;
      if (sub) vv = (~vv) & m;
      r  = uu + vv + 64'(sub);
      s  = s | 48'((r & m) << (i * w));
      c[i] = r[w];
    end
  endfunction

  function automatic logic [47:0] ref_logic(input logic [3:0] ls, input logic [47:0] x, input logic [47:0] y);
    case (ls)
      4'd0: return x & y;
      4'd1: return x | y;
      4'd2: return x ^ y;
      4'd3: return ~(x ^ y);
      4'd4: return ~(x & y);
      4'd5: return ~(x | y);
      4'd6: return x & ~y;
      4'd7: return ~x;
      4'd8: return x | ~y;
      4'd9: return x;
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op, input logic cl);
    if (cl) return "R9";
    case (op)
      4'd0, 4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4, 4'd5: return "R5";
      4'd6, 4'd7: return "R6";
      4'd8:       return "R8";
      default:    return "R10";
    endcase
  endfunction

  // reference model: updates model_acc, returns expected carry
  function automatic logic [3:0] model(input logic [3:0] op, input logic [3:0] ls, input logic [1:0] sm,
                                       input logic cl, input logic [24:0] a, input logic [24:0] d,
                                       input logic [17:0] b, input logic [47:0] x, input logic [47:0] y);
    logic [24:0] pre;
    longint      pr;
    logic [47:0] prod, s;
    logic [3:0]  c;
    pre  = (op == 4'd1 || op == 4'd3) ? 25'(a + d) : a;
    pr   = longint'($signed(pre)) * longint'($signed(b));
    prod = 48'(pr);
    c    = '0;
    if (cl) begin
      model_acc = '0;
      return 4'd0;
    end
    case (op)
      4'd0, 4'd1: model_acc = prod;
      4'd2, 4'd3: model_acc = model_acc + prod;
      4'd4: begin lanes(x, y, 1'b0, sm, s, c); model_acc = s; end
      4'd5: begin lanes(x, y, 1'b1, sm, s, c); model_acc = s; end
      4'd6: begin lanes(model_acc, x, 1'b0, sm, s, c); model_acc = s; end
      4'd7: begin lanes(model_acc, x, 1'b1, sm, s, c); model_acc = s; end
      4'd8: model_acc = ref_logic(ls, x, y);
      default: ;
    endcase
    return c;
  endfunction

  task automatic step(input string tag, input logic [3:0] op, input logic [3:0] ls, input logic [1:0] sm,
                      input logic cl, input logic [24:0] a, input logic [24:0] d, input logic [17:0] b,
                      input logic [47:0] x, input logic [47:0] y);
    logic [47:0] ep;
    logic [3:0]  ec, c;
    string       et;
    @(negedge clk);
    if (qp.size() == LAT) begin
      ep = qp.pop_front();
      ec = qc.pop_front();
      et = qt.pop_front();
      checks++;
      if (p_out !== ep) begin
        fails++;
        $display("FAIL %s p_out actual=%h expected=%h", et, p_out, ep);
      end
      checks++;
      if (carry_out !== ec) begin
        fails++;
        $display("FAIL R7 (%s) carry_out actual=%b expected=%b", et, carry_out, ec);
      end
    end
    op_in = op; logic_sel = ls; simd_mode = sm; clr_acc = cl;
    mul_a = a; mul_d = d; mul_b = b; opnd_x = x; opnd_y = y;
    c = model(op, ls, sm, cl, a, d, b, x, y);
    qp.push_back(model_acc);
    qc.push_back(c);
    qt.push_back(tag.len() > 0 ? tag : tag_of(op, cl));
  endtask

  task automatic nop(input string tag);
    step(tag, 4'd15, 4'd0, 2'd0, 1'b0, '0, '0, '0, 48'h123456789ABC, '0);
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    logic [47:0] ones;
    ones = '1;
    void'($urandom(32'd20250101));
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    checks++;
    if (p_out !== '0 || carry_out !== '0) begin
      fails++;
      $display("FAIL R1 reset actual=%h/%b expected=0/0", p_out, carry_out);
    end
    rst = 1'b0;
    repeat (LAT + 1) nop("R1");

    // R2: back-to-back accumulation after a clear
    step("R2", 4'd2, 4'd0, 2'd0, 1'b1, 25'd3, '0, 18'd5, '0, '0);
    repeat (3) step("R2", 4'd2, 4'd0, 2'd0, 1'b0, 25'd3, '0, 18'd5, '0, '0);
    step("R4", 4'd3, 4'd0, 2'd0, 1'b0, 25'h1FFFFFF, 25'd10, 18'h3FFFF, '0, '0);

    // R3: pre-add wrap and extreme factors
    step("R3", 4'd1, 4'd0, 2'd0, 1'b0, 25'h0800000, 25'h0800000, 18'd1, '0, '0);
    step("R3", 4'd0, 4'd0, 2'd1, 1'b0, 25'h1000000, '0, 18'h20000, '0, '0);
    step("R3", 4'd0, 4'd0, 2'd2, 1'b0, 25'h0FFFFFF, '0, 18'h20000, '0, '0);

    // R5 / R7: carries right at lane boundaries
    step("R5", 4'd4, 4'd0, 2'd2, 1'b0, '0, '0, '0, ones, 48'h001001001001);
    step("R5", 4'd4, 4'd0, 2'd0, 1'b0, '0, '0, '0, ones, 48'h000000000001);
    step("R5", 4'd4, 4'd0, 2'd1, 1'b0, '0, '0, '0, ones, 48'h000001000001);
    step("R5", 4'd4, 4'd0, 2'd3, 1'b0, '0, '0, '0, ones, 48'h000000000001);
    step("R5", 4'd5, 4'd0, 2'd2, 1'b0, '0, '0, '0, 48'h000001000001, 48'h001001001001);
    step("R5", 4'd5, 4'd0, 2'd1, 1'b0, '0, '0, '0, '0, 48'h000001000000);

    // R6: up/down counter
    step("R9", 4'd6, 4'd0, 2'd0, 1'b1, '0, '0, '0, 48'd1, '0);
    repeat (4) step("R6", 4'd6, 4'd0, 2'd0, 1'b0, '0, '0, '0, 48'd1, '0);
    repeat (6) step("R6", 4'd7, 4'd0, 2'd0, 1'b0, '0, '0, '0, 48'd1, '0);
    repeat (2) step("R6", 4'd6, 4'd0, 2'd2, 1'b0, '0, '0, '0, 48'h001001001001, '0);

    // R8: every logic select value
    for (int s = 0; s < 16; s++)
      step("R8", 4'd8, 4'(s), 2'd0, 1'b0, '0, '0, '0, 48'hF0F0_CC33_A5A5, 48'hFF00_AAAA_0F0F);

    // R10: reserved codes hold the result
    for (int k = 9; k < 16; k++)
      step("R10", 4'(k), 4'd0, 2'd2, 1'b0, 25'h1234, 25'h77, 18'h99, ones, ones);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [3:0] op;
      r  = int'($urandom_range(0, 19));
      op = (r > 15) ? 4'd8 : 4'(r);
      step("", op, 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
           ($urandom_range(0, 15) == 0),
           25'($urandom()), 25'($urandom()), 18'($urandom()),
           48'({$urandom(), $urandom()}), 48'({$urandom(), $urandom()}));
    end

    repeat (LAT) nop("R10");
    done = 1'b1;
    report();
  end

endmodule